// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block decides which clocks of a small microcontroller run. Software selects one of six operating levels: active, or one of five low-power levels numbered LPM0 to LPM4. The block turns the selected level into six enables. These cover the CPU, the main clock, the sub-main clock, the auxiliary clock, the DC generator of the digitally controlled oscillator, and the crystal oscillator. A selection is a 3-bit code written with a one-cycle strobe.

A pending interrupt (`wake_req`) moves the block at once to full activity. The level in force at that moment is kept in a save register. The interrupt-return strobe (`irq_ret`) puts that level back. While the service routine runs, software may write a new code. That code replaces the saved level, so the return lands in the new level. The analog oscillators, the clock dividers and the CPU are outside this block.

The sequencer has three states:
- `ST_RUN`: normal operation. The current level drives the enables.
- `ST_SERVICE`: an interrupt is being served. Every enable is on.
- `ST_RESTORE`: the one cycle after a return strobe. The saved level is reapplied at its end.

The transitions are:
- RUN→SERVICE on wake.
- SERVICE→RESTORE on return.
- RESTORE→RUN normally.
- RESTORE→SERVICE if a wake arrives in that cycle.

Top module: `lpm_clock_gate_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the level is active (code 0) and all six enables are 1.
- R2: Code 0 (active) sets all six enables to 1.
- R3: Code 1 (LPM0) clears the CPU and main clock enables. It keeps the sub-main, auxiliary, DC generator and crystal enables at 1.
- R4: Code 2 (LPM1) gates like code 1. The exception is the DC generator enable, which follows the `dco_busy_active` input.
- R5: Code 3 (LPM2) clears the CPU, main and sub-main enables. It keeps the auxiliary, DC generator and crystal enables at 1.
- R6: Code 4 (LPM3) gates like code 3, except that the DC generator enable is 0.
- R7: Code 5 (LPM4) clears all six enables.
- R8: In `ST_RUN`, a code written with `mode_wr` takes effect on the enables right after the clock edge that samples it. Codes 6 and 7 are ignored.
- R9: In `ST_RUN`, a sampled `wake_req` turns all enables on after that edge, from any level, and saves the current level. A `mode_wr` in the same cycle is dropped.
- R10: When `irq_ret` is sampled in `ST_SERVICE`, the enables stay all on for one more cycle (`ST_RESTORE`). The saved level drives them after the following edge.
- R11: A valid `mode_wr` in `ST_SERVICE` or `ST_RESTORE` leaves all enables on and replaces the level that the return restores.
- R12: A `wake_req` during `ST_RESTORE` goes back to `ST_SERVICE` and keeps the saved level. In `ST_RUN`, `irq_ret` with no wake and no write has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_wr | input | 1 | Strobe: write `mode_code` |
| mode_code | input | 3 | Requested level, 0 active, 1..5 LPM0..LPM4 |
| wake_req | input | 1 | Pending interrupt |
| irq_ret | input | 1 | Interrupt-return strobe |
| dco_busy_active | input | 1 | Oscillator in use while active; keeps the DC generator on in LPM1 |
| cpu_en | output | 1 | CPU enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Sub-main clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| dcgen_en | output | 1 | DC generator enable |
| xosc_en | output | 1 | Crystal oscillator enable |

## Verification
The bench goes after the corner cases of the save and restore path.

- **Wake and write in the same cycle.** A design that gave the write priority would save the wrong level, or stay asleep.
- **Write during service.** A design that applied the write directly would gate the CPU while it is still serving the interrupt.
- **Wake during the restore cycle.** A design that ignored it would drop back into sleep with the interrupt pending.
- **Stray return strobe.** A design that acted on it would jump to a stale saved level.
- **Invalid codes 6 and 7.** A design that accepted them would emit an undefined gating pattern.
- **LPM1 with both values of the oscillator-use input.** A design that ignored the input would waste power, or stop an oscillator still in use.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    localparam int MODE_W    = 3;
    localparam int NUM_MODES = 6;
    localparam int GATE_W    = 6;

    typedef enum logic [MODE_W-1:0] {
        MODE_ACTIVE = 3'd0,
        MODE_LP0    = 3'd1,
        MODE_LP1    = 3'd2,
        MODE_LP2    = 3'd3,
        MODE_LP3    = 3'd4,
        MODE_LP4    = 3'd5
    } lpm_mode_e;

    typedef enum logic [1:0] {
        ST_RUN     = 2'd0,
        ST_SERVICE = 2'd1,
        ST_RESTORE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic cpu;
        logic mclk;
        logic smclk;
        logic aclk;
        logic dcgen;
        logic xosc;
    } gate_en_t;

    function automatic logic code_is_valid(input logic [MODE_W-1:0] code);
        return (int'(code) < NUM_MODES);
    endfunction

endpackage

// File: rtl/lpm_gate_decode.sv
module lpm_gate_decode
    import lpm_pkg::*;
(
    input  lpm_mode_e mode,
    input  logic      dco_busy,
    output gate_en_t  gates
);

    always_comb begin
        gates = '{default: 1'b1};
        unique case (mode)
            MODE_ACTIVE: gates = '{default: 1'b1};
            MODE_LP0: begin
                gates.cpu  = 1'b0;
                gates.mclk = 1'b0;
            end
            MODE_LP1: begin
                gates.cpu   = 1'b0;
                gates.mclk  = 1'b0;
                gates.dcgen = dco_busy;
            end
            MODE_LP2: begin
                gates.cpu   = 1'b0;
                gates.mclk  = 1'b0;
                gates.smclk = 1'b0;
            end
            MODE_LP3: begin
                gates.cpu   = 1'b0;
                gates.mclk  = 1'b0;
                gates.smclk = 1'b0;
                gates.dcgen = 1'b0;
            end
            MODE_LP4: gates = '{default: 1'b0};
            default:  gates = '{default: 1'b1};
        endcase
    end

endmodule

// File: rtl/lpm_seq_fsm.sv
module lpm_seq_fsm
    import lpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_wr,
    input  logic [MODE_W-1:0] mode_code,
    input  logic              wake,
    input  logic              irq_ret,
    output lpm_mode_e         eff_mode,
    output logic              in_isr
);

    seq_state_e state_q, state_d;
    lpm_mode_e  cur_q, cur_d;
    lpm_mode_e  saved_q, saved_d;
    logic       wr_ok;

    assign wr_ok = mode_wr && code_is_valid(mode_code);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            cur_q   <= MODE_ACTIVE;
            saved_q <= MODE_ACTIVE;
        end else begin
            state_q <= state_d;
            cur_q   <= cur_d;
            saved_q <= saved_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cur_d   = cur_q;
        saved_d = saved_q;
        unique case (state_q)
            ST_RUN: begin
                if (wake) begin
                    saved_d = cur_q;
                    cur_d   = MODE_ACTIVE;
                    state_d = ST_SERVICE;
                end else if (wr_ok) begin
                    cur_d = lpm_mode_e'(mode_code);
                end
            end
            ST_SERVICE: begin
                if (wr_ok) saved_d = lpm_mode_e'(mode_code);
                if (irq_ret) state_d = ST_RESTORE;
            end
            ST_RESTORE: begin
                if (wr_ok) saved_d = lpm_mode_e'(mode_code);
                if (wake) begin
                    state_d = ST_SERVICE;
                end else begin
                    cur_d   = saved_d;
                    state_d = ST_RUN;
                end
            end
            default: begin
                state_d = ST_RUN;
                cur_d   = MODE_ACTIVE;
            end
        endcase
    end

    assign eff_mode = cur_q;
    assign in_isr   = (state_q != ST_RUN);

    assert_wake_saves_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && wake) |=>
            (state_q == ST_SERVICE && cur_q == MODE_ACTIVE && saved_q == $past(cur_q)));

    assert_restore_applies_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RESTORE && !wake && !mode_wr) |=>
            (state_q == ST_RUN && cur_q == $past(saved_q)));

    assert_bad_code_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !wake && mode_wr && !code_is_valid(mode_code)) |=> $stable(cur_q));

    assert_stray_ret_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && !wake && !mode_wr && irq_ret) |=>
            ($stable(cur_q) && state_q == ST_RUN));

    assert_isr_write_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SERVICE && !irq_ret) |=> (cur_q == MODE_ACTIVE && state_q == ST_SERVICE));

endmodule

// File: rtl/lpm_clock_gate_ctrl.sv
module lpm_clock_gate_ctrl
    import lpm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       mode_wr,
    input  logic [2:0] mode_code,
    input  logic       wake_req,
    input  logic       irq_ret,
    input  logic       dco_busy_active,
    output logic       cpu_en,
    output logic       mclk_en,
    output logic       smclk_en,
    output logic       aclk_en,
    output logic       dcgen_en,
    output logic       xosc_en
);

    lpm_mode_e eff_mode;
    logic      in_isr;
    gate_en_t  gates;

    lpm_seq_fsm u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_wr   (mode_wr),
        .mode_code (mode_code),
        .wake      (wake_req),
        .irq_ret   (irq_ret),
        .eff_mode  (eff_mode),
        .in_isr    (in_isr)
    );

    lpm_gate_decode u_dec (
        .mode     (eff_mode),
        .dco_busy (dco_busy_active),
        .gates    (gates)
    );

    assign cpu_en   = gates.cpu;
    assign mclk_en  = gates.mclk;
    assign smclk_en = gates.smclk;
    assign aclk_en  = gates.aclk;
    assign dcgen_en = gates.dcgen;
    assign xosc_en  = gates.xosc;

    assert_isr_all_on_R9: assert property (@(posedge clk) disable iff (!rst_n)
        in_isr |-> (cpu_en && mclk_en && smclk_en && aclk_en && dcgen_en && xosc_en));

    assert_lp4_dark_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_mode == MODE_LP4) |-> !(cpu_en || mclk_en || smclk_en || aclk_en || dcgen_en || xosc_en));

    assert_cpu_with_mclk_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en == mclk_en);

    assert_smclk_needs_aclk_R5: assert property (@(posedge clk) disable iff (!rst_n)
        smclk_en |-> aclk_en);

endmodule

// File: tb/lpm_clock_gate_ctrl_tb.sv
module lpm_clock_gate_ctrl_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_wr = 1'b0;
    logic [2:0] mode_code = 3'd0;
    logic       wake_req = 1'b0;
    logic       irq_ret = 1'b0;
    logic       dco_busy_active = 1'b1;
    logic       cpu_en, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [5:0] exp_q[$];
    string      tag_q[$];

    // enable vector order: {cpu, mclk, smclk, aclk, dcgen, xosc}
    localparam logic [5:0] ALL_ON = 6'b111111;
    localparam logic [5:0] G_LP0  = 6'b001111;
    localparam logic [5:0] G_LP1N = 6'b001101;
    localparam logic [5:0] G_LP2  = 6'b000111;
    localparam logic [5:0] G_LP3  = 6'b000101;
    localparam logic [5:0] G_LP4  = 6'b000000;

    always #4 clk = ~clk;

    lpm_clock_gate_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_code(mode_code),
        .wake_req(wake_req), .irq_ret(irq_ret), .dco_busy_active(dco_busy_active),
        .cpu_en(cpu_en), .mclk_en(mclk_en), .smclk_en(smclk_en),
        .aclk_en(aclk_en), .dcgen_en(dcgen_en), .xosc_en(xosc_en)
    );

    function automatic logic [5:0] outs();
        return {cpu_en, mclk_en, smclk_en, aclk_en, dcgen_en, xosc_en};
    endfunction

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: enables actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // driver: set inputs for one cycle, push the enables expected after the edge
    task automatic step(input logic wr, input logic [2:0] code, input logic wk,
                        input logic ret, input logic dco, input logic [5:0] exp,
                        input string tag);
        @(negedge clk);
        mode_wr = wr; mode_code = code; wake_req = wk; irq_ret = ret;
        dco_busy_active = dco;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // monitor: compare after each rising edge
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            logic [5:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(outs(), e, t);
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(outs(), ALL_ON, "R1 during reset");
        rst_n = 1'b1;
        step(0, 3'd0, 0, 0, 1, ALL_ON, "R1 after reset");
        step(1, 3'd0, 0, 0, 1, ALL_ON, "R2 active");
        step(1, 3'd1, 0, 0, 1, G_LP0,  "R3 LPM0");
        step(1, 3'd2, 0, 0, 1, G_LP0,  "R4 LPM1 dco used");
        step(0, 3'd0, 0, 0, 0, G_LP1N, "R4 LPM1 dco unused");
        step(1, 3'd3, 0, 0, 0, G_LP2,  "R5 LPM2");
        step(1, 3'd4, 0, 0, 1, G_LP3,  "R6 LPM3");
        step(1, 3'd5, 0, 0, 1, G_LP4,  "R7 LPM4");
        step(1, 3'd6, 0, 0, 1, G_LP4,  "R8 code 6 ignored");
        step(1, 3'd7, 0, 0, 1, G_LP4,  "R8 code 7 ignored");
        // wake from LPM4, return restores it
        step(0, 3'd0, 1, 0, 1, ALL_ON, "R9 wake from LPM4");
        step(0, 3'd0, 0, 0, 1, ALL_ON, "R10 in service");
        step(0, 3'd0, 0, 1, 1, ALL_ON, "R10 restore cycle");
        step(0, 3'd0, 0, 0, 1, G_LP4,  "R10 LPM4 restored");
        step(0, 3'd0, 0, 1, 1, G_LP4,  "R12 stray return");
        // wake beats a write in the same cycle
        step(1, 3'd3, 0, 0, 1, G_LP2,  "R8 LPM2 write");
        step(1, 3'd1, 1, 0, 1, ALL_ON, "R9 wake over write");
        step(0, 3'd0, 0, 0, 1, ALL_ON, "R9 service");
        step(0, 3'd0, 0, 1, 1, ALL_ON, "R10 restore cycle");
        step(0, 3'd0, 0, 0, 1, G_LP2,  "R9 LPM2 restored, write dropped");
        // write during service changes the return level
        step(0, 3'd0, 1, 0, 1, ALL_ON, "R9 wake from LPM2");
        step(1, 3'd1, 0, 0, 1, ALL_ON, "R11 write in service stays on");
        step(0, 3'd0, 0, 1, 1, ALL_ON, "R11 restore cycle");
        step(0, 3'd0, 0, 0, 1, G_LP0,  "R11 new level LPM0");
        // wake during restore cycle
        step(0, 3'd0, 1, 0, 1, ALL_ON, "R12 wake");
        step(0, 3'd0, 0, 1, 1, ALL_ON, "R12 restore cycle");
        step(0, 3'd0, 1, 0, 1, ALL_ON, "R12 wake in restore");
        step(0, 3'd0, 0, 0, 1, ALL_ON, "R12 back in service");
        step(0, 3'd0, 0, 1, 1, ALL_ON, "R12 second restore cycle");
        step(0, 3'd0, 0, 0, 1, G_LP0,  "R12 saved LPM0 kept");
        // interrupt while active
        step(1, 3'd0, 0, 0, 1, ALL_ON, "R2 back to active");
        step(0, 3'd0, 1, 0, 1, ALL_ON, "R9 wake while active");
        step(0, 3'd0, 0, 1, 1, ALL_ON, "R10 restore cycle");
        step(0, 3'd0, 0, 0, 1, ALL_ON, "R10 active restored");
        @(negedge clk);
        mode_wr = 0; wake_req = 0; irq_ret = 0;
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL scoreboard: actual=%0d left expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule